// File: doc/BRIEF.md
# Keyboard-Scan Peripheral Port with CA2 Interrupt

This block is a small memory-mapped register file that a CPU uses to drive a keyboard matrix and to learn when a key is down. A write to the port B offset does not store a byte. It sets or clears one bit of an eight-bit addressable latch, and one bit of that latch is an active-low keyboard write enable. Port A has an output register and a data direction register. The scan software drives a column and row number on the low seven bits and reads the key-present answer back on bit 7, which is set as an input.

A key press pulls the CA2 control line low. The block passes CA2 through a synchronizer, detects its falling edge and sets a flag. The flag is always recorded. It drives the active-low interrupt output only when the matching enable bit is set. This lets scan software mask the interrupt, clear the flag and poll it again for each column it tries.

Top module: `kbd_port_irq`

## Requirements
- R1: After reset the latch reads 0xFF, the direction register, port A output register, CA2 flag and CA2 enable are all 0, and irq_n is 1.
- R2: A write to offset 0 changes only latch bit wdata[2:0] and gives it the value wdata[3]. The other seven latch bits keep their values, and the latch does not change on any other write.
- R3: Writing 0x03 to offset 0 clears latch bit 3 (keyboard write enabled, active low). Writing 0x0B sets it again (disabled).
- R4: Offset 3 is the direction register. It reads back what was written, and pa_oe equals it bit for bit (1 = output).
- R5: A write to offset 15 stores the port A output register, which appears on pa_out. A read of offset 15 returns the output register bits where direction is 1 and the pa_pin bits where direction is 0.
- R6: A falling edge on ca2_in sets the CA2 flag (bit 0 of offset 13) on the third rising clock edge after the input changes. This happens whether or not the interrupt is enabled. A rising edge or a steady level does not set it.
- R7: Writing offset 13 with bit 0 = 1 clears the CA2 flag. With bit 0 = 0 the flag is left as it is. A later falling edge sets it again.
- R8: A write to offset 14 with bit 7 = 1 sets the enable bits selected by 1s in the data (CA2 is bit 0). With bit 7 = 0 it clears them. A read of offset 14 returns the enable in bit 0 and 0 elsewhere.
- R9: irq_n is 0 exactly when both the CA2 flag and the CA2 enable are 1, with no added register delay. Bit 7 of offset 13 reads as that same flag-and-enable term.
- R10: Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ca2_in | input | 1 | Asynchronous CA2 control line, active low |
| pa_pin | input | 8 | Port A pin read-back |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A direction (1 = drive) |
| latch_q | output | 8 | Addressable latch contents |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A register write takes effect at the rising edge on which it is strobed. Reads and irq_n are combinational, so the bench drives at falling edges and samples just after the next falling edge. A CA2 change needs three rising edges before the flag shows: two synchronizer stages and then the flag register. The bench checks that the flag is still clear after two edges and set after the third. Tests that depend on irq_n look at it in the same half-cycle in which the flag or enable register changes. This confirms that no register stage was added on that path.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  localparam logic [AW-1:0] OFS_LATCH = 4'd0;
  localparam logic [AW-1:0] OFS_DIR   = 4'd3;
  localparam logic [AW-1:0] OFS_FLAG  = 4'd13;
  localparam logic [AW-1:0] OFS_EN    = 4'd14;
  localparam logic [AW-1:0] OFS_PA    = 4'd15;

  // one-bit update of the addressable latch: index in low bits, value above it
  function automatic logic [DW-1:0] latch_next(input logic [DW-1:0] q,
                                               input logic [DW-1:0] wd);
    localparam int IW = $clog2(DW);
    logic [DW-1:0] r;
    r = q;
    r[wd[IW-1:0]] = wd[IW];
    return r;
  endfunction

  // direction-masked read of port A
  function automatic logic [DW-1:0] pa_view(input logic [DW-1:0] outr,
                                            input logic [DW-1:0] dir,
                                            input logic [DW-1:0] pin);
    return (outr & dir) | (pin & ~dir);
  endfunction

  // set/clear style enable update: msb picks the sense
  function automatic logic [DW-2:0] en_next(input logic [DW-2:0] en,
                                            input logic [DW-1:0] wd);
    return wd[DW-1] ? (en | wd[DW-2:0]) : (en & ~wd[DW-2:0]);
  endfunction
endpackage

// File: rtl/kbd_addr_latch.sv
module kbd_addr_latch
  import kbd_port_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= latch_next(q, wdata);
  end

  assert_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(q ^ $past(q)) <= 1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/kbd_port_a.sv
module kbd_port_a
  import kbd_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_wr,
  input  logic          out_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] rd_view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_wr) dir_q <= wdata;
      if (out_wr) out_q <= wdata;
    end
  end

  assign rd_view = pa_view(out_q, dir_q, pin);

  assert_dir_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (dir_q == $past(wdata)));
  assert_input_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((rd_view ^ pin) & ~dir_q) == '0));
endmodule

// File: rtl/kbd_ca2_irq.sv
module kbd_ca2_irq
  import kbd_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ca2_in,
  input  logic          flag_wr,
  input  logic          en_wr,
  input  logic [DW-1:0] wdata,
  output logic          flag_q,
  output logic          en_q,
  output logic          fall_evt,
  output logic          irq_n
);
  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] sync_q;
  logic          prev_q;
  logic [DW-2:0] en_vec;
  logic          clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[NS-2:0], ca2_in};
      prev_q <= sync_q[NS-1];
    end
  end

  assign fall_evt = prev_q & ~sync_q[NS-1];
  assign clr_evt  = flag_wr & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (fall_evt) flag_q <= 1'b1;
    else if (clr_evt)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_vec <= '0;
    else if (en_wr)  en_vec <= en_next(en_vec, wdata);
  end

  // only the CA2 source exists; other enable bits are not kept
  assign en_q  = en_vec[0];
  assign irq_n = ~(flag_q & en_q);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> flag_q);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !fall_evt) |=> !flag_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !fall_evt) |=> !flag_q);
  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && wdata[DW-1] && wdata[0]) |=> en_q);
  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> irq_n);
endmodule

// File: rtl/kbd_port_irq.sv
module kbd_port_irq
  import kbd_port_pkg::*;
#(
  parameter logic [DW-1:0] LATCH_RST   = 8'hFF,
  parameter int            SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ca2_in,
  input  logic [DW-1:0] pa_pin,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] latch_q,
  output logic          irq_n
);
  logic          wr_any;
  logic          wr_latch, wr_dir, wr_flag, wr_en, wr_pa;
  logic          flag_q, en_q, fall_evt;
  logic [DW-1:0] pa_rd;

  assign wr_any   = bus_sel & bus_wr;
  assign wr_latch = wr_any && (bus_addr == OFS_LATCH);
  assign wr_dir   = wr_any && (bus_addr == OFS_DIR);
  assign wr_flag  = wr_any && (bus_addr == OFS_FLAG);
  assign wr_en    = wr_any && (bus_addr == OFS_EN);
  assign wr_pa    = wr_any && (bus_addr == OFS_PA);

  kbd_addr_latch #(.RST_VAL(LATCH_RST)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_latch), .wdata(bus_wdata), .q(latch_q)
  );

  kbd_port_a u_pa (
    .clk(clk), .rst_n(rst_n), .dir_wr(wr_dir), .out_wr(wr_pa),
    .wdata(bus_wdata), .pin(pa_pin), .dir_q(pa_oe), .out_q(pa_out),
    .rd_view(pa_rd)
  );

  kbd_ca2_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .ca2_in(ca2_in), .flag_wr(wr_flag),
    .en_wr(wr_en), .wdata(bus_wdata), .flag_q(flag_q), .en_q(en_q),
    .fall_evt(fall_evt), .irq_n(irq_n)
  );

  always_comb begin
    case (bus_addr)
      OFS_LATCH: bus_rdata = latch_q;
      OFS_DIR:   bus_rdata = pa_oe;
      OFS_FLAG:  bus_rdata = {~irq_n, {(DW-2){1'b0}}, flag_q};
      OFS_EN:    bus_rdata = {{(DW-1){1'b0}}, en_q};
      OFS_PA:    bus_rdata = pa_rd;
      default:   bus_rdata = '0;
    endcase
  end

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9,
                      4'd10, 4'd11, 4'd12}) |-> (bus_rdata == '0));
  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_q && en_q));
endmodule

// File: tb/kbd_port_irq_bench.sv
module kbd_port_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ca2_in = 1'b1;
  logic [7:0] pa_pin = '0;
  logic [7:0] pa_out, pa_oe, latch_q;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_latch;

  always #4 clk = ~clk;

  kbd_port_irq u_kbd_port_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ca2_in(ca2_in), .pa_pin(pa_pin), .pa_out(pa_out), .pa_oe(pa_oe),
    .latch_q(latch_q), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 latch", latch_q, 8'hFF);
    check("R1 dir", pa_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    rd(4'd13, v); check("R1 flag", v, 8'h00);
    rd(4'd14, v); check("R1 en", v, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    exp_latch = 8'hFF;
    wr(4'd0, 8'h05); exp_latch[5] = 1'b0;
    check("R2 clear bit5", latch_q, exp_latch);
    wr(4'd0, 8'h00); exp_latch[0] = 1'b0;
    check("R2 clear bit0", latch_q, exp_latch);
    wr(4'd0, 8'h0D); exp_latch[5] = 1'b1;
    check("R2 set bit5", latch_q, exp_latch);
    wr(4'd3, 8'h0F);
    check("R2 other write", latch_q, exp_latch);
    rd(4'd0, v); check("R2 readback", v, exp_latch);
  endtask

  task automatic t_kbd_enable();
    wr(4'd0, 8'h03); exp_latch[3] = 1'b0;
    check("R3 enable kbd", latch_q, exp_latch);
    wr(4'd0, 8'h0B); exp_latch[3] = 1'b1;
    check("R3 disable kbd", latch_q, exp_latch);
  endtask

  task automatic t_port_a();
    logic [7:0] v;
    wr(4'd3, 8'h7F);
    rd(4'd3, v); check("R4 dir read", v, 8'h7F);
    check("R4 pa_oe", pa_oe, 8'h7F);
    pa_pin = 8'hAA;
    wr(4'd15, 8'h55);
    check("R5 pa_out", pa_out, 8'h55);
    rd(4'd15, v); check("R5 mixed read", v, 8'hD5);
    pa_pin = 8'h2A;
    rd(4'd15, v); check("R5 pin bit7 low", v, 8'h55);
    wr(4'd3, 8'h00);
    rd(4'd15, v); check("R5 all inputs", v, 8'h2A);
  endtask

  task automatic t_ca2_poll();
    logic [7:0] v;
    @(negedge clk); ca2_in = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(4'd13, v); check("R6 not yet after two edges", v, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(4'd13, v); check("R6 flag set, masked", v, 8'h01);
    check("R6 irq_n masked", {7'b0, irq_n}, 8'h01);
    wr(4'd13, 8'h00);
    rd(4'd13, v); check("R7 zero write keeps flag", v, 8'h01);
    wr(4'd13, 8'h01);
    rd(4'd13, v); check("R7 flag cleared", v, 8'h00);
    repeat (4) @(negedge clk);
    rd(4'd13, v); check("R6 steady low no set", v, 8'h00);
    ca2_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd13, v); check("R6 rising edge no set", v, 8'h00);
    ca2_in = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    rd(4'd13, v); check("R7 re-set after clear", v, 8'h01);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd14; bus_wdata = 8'h81;
    @(posedge clk); #1;
    check("R9 irq same edge as enable", {7'b0, irq_n}, 8'h00);
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    rd(4'd14, v); check("R8 enable set", v, 8'h01);
    rd(4'd13, v); check("R9 flag reg bit7", v, 8'h81);
    wr(4'd14, 8'h01);
    rd(4'd14, v); check("R8 enable cleared", v, 8'h00);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);
    wr(4'd14, 8'h81);
    check("R9 irq again", {7'b0, irq_n}, 8'h00);
    wr(4'd13, 8'h01);
    check("R9 irq off on clear", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    rd(4'd1, v);  check("R10 offset 1", v, 8'h00);
    rd(4'd7, v);  check("R10 offset 7", v, 8'h00);
    rd(4'd12, v); check("R10 offset 12", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        #200_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_latch();
    t_kbd_enable();
    t_port_a();
    t_ca2_poll();
    t_irq();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule